// File: doc/BRIEF.md
# Per-Core Countdown Interrupt Timer

This block is a private countdown timer for one processor core. Software programs it through a small word-wide register port that uses four slots in a 4 KB page. After a start value is written, a down-counter runs at the core clock divided by a selectable power of two. When the count expires, the timer offers an interrupt to its own core, tagged with an 8-bit vector chosen by software. It can fire once and stop, or reload and fire at a fixed rate.

The interrupt leaves the block as a valid/ready stream of one vector. `irq_valid` stays high, and `irq_vector` stays constant, until the core takes the interrupt by driving `irq_ready` in a clock cycle where `irq_valid` is high. While a delivery waits, the busy bit in the control register reads 1. Further expiries that happen during that wait are absorbed and are not counted. If `irq_ready` is held low, the block keeps waiting as long as needed, and the counter keeps running in the meantime. If a new expiry falls in the same cycle that the core accepts the pending interrupt, a fresh interrupt is offered straight away.

Register map (byte offsets inside the page; bits [3:0] of the address are ignored): control at 0x320, start count at 0x380, live count at 0x390, clock divider at 0x3E0. Reads return data in the same cycle. Any other offset reads zero and ignores writes.

Top module: `core_timer`

## Requirements
- R1: After reset, control reads 0x0001_0000 (masked, one-shot, vector 0), start count, live count and divider read 0, and `irq_valid` is low.
- R2: Control bits [7:0] hold the vector, bit 16 is mask (1 = silent), bit 17 is mode (1 = periodic, 0 = one-shot) and bit 12 is a read-only busy flag. All other bits read 0, so writing all ones reads back 0x0003_00FF while no delivery waits.
- R3: The divider register keeps only bits 3, 1 and 0. Every other bit reads 0, so writing all ones reads back 0x0000_000B.
- R4: A write to the start count loads the same value into the live count in that clock edge and restarts the prescaler.
- R5: The live count drops by one per prescaled tick. With divide factor D and start value N (N > 0), the interrupt becomes visible after the D*N-th rising edge that follows the write edge.
- R6: The divider code {bit3,bit1,bit0} selects the factor: 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1.
- R7: In one-shot mode the live count stays at 0 after an expiry, and no further interrupt follows.
- R8: In periodic mode the live count reloads from the start count at expiry, and interrupts recur every D*N edges.
- R9: While mask is 1, expiries raise no interrupt.
- R10: A raised interrupt holds `irq_valid`, a constant `irq_vector` equal to the control vector at expiry, and busy = 1, until an edge where `irq_ready` is high.
- R11: Expiries that occur while a delivery waits are dropped. After the core accepts the interrupt, nothing is pending until the next expiry.
- R12: Writing 0 to the start count stops the timer with live count 0 and no interrupt.
- R13: Writes to the live-count slot are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (12) | Byte offset in the register page |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid in the same cycle as the strobe |
| irq_valid | output | 1 | Interrupt offered to the core |
| irq_vector | output | 8 | Vector of the offered interrupt |
| irq_ready | input | 1 | Core takes the offered interrupt |

## Verification
The assertions assume that `irq_ready` is only acted on while `irq_valid` is high. They also assume that register reads hit the decoded slots with the word-aligned offsets listed above. The bench drives every access and the ready pulse on the falling clock edge, for exactly one cycle, and asserts ready only after it has seen a pending interrupt. It stops any periodic run by writing a start count of 0 before it reprograms the divider or the mode. This keeps the one-shot and periodic checks free of leftover expiries.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int PRE_W = 7;
  localparam logic [11:0] OFF_CTRL  = 12'h320;
  localparam logic [11:0] OFF_START = 12'h380;
  localparam logic [11:0] OFF_LIVE  = 12'h390;
  localparam logic [11:0] OFF_DIV   = 12'h3E0;

  localparam int BIT_BUSY = 12;
  localparam int BIT_MASK = 16;
  localparam int BIT_MODE = 17;

  typedef struct packed {
    logic       periodic;
    logic       mask;
    logic [7:0] vector;
  } ctrl_t;

  // Prescaler compare mask: factor - 1 for the 3-bit divider code.
  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] code);
    logic [7:0] pw;
    if (code == 3'b111) return '0;
    pw = 8'd1 << ({1'b0, code} + 4'd1);
    return PRE_W'(pw - 8'd1);
  endfunction
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              busy,
  output ctrl_t             ctrl,
  output logic [2:0]        div_code,
  output logic              start_stb,
  output logic [CNT_W-1:0]  start_cnt
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic sel_ctrl, sel_start, sel_live, sel_div;
  logic wr;
  ctrl_t ctrl_q;
  logic [2:0] div_q;
  logic [CNT_W-1:0] start_q;
  logic unused_bits;

  assign slot      = reg_addr[ADDR_W-1:4];
  assign sel_ctrl  = (slot == SLOT_W'(OFF_CTRL  >> 4));
  assign sel_start = (slot == SLOT_W'(OFF_START >> 4));
  assign sel_live  = (slot == SLOT_W'(OFF_LIVE  >> 4));
  assign sel_div   = (slot == SLOT_W'(OFF_DIV   >> 4));
  assign wr        = reg_en & reg_we;
  assign unused_bits = ^{reg_addr[3:0], reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '{periodic: 1'b0, mask: 1'b1, vector: 8'h00};
      div_q   <= 3'b000;
      start_q <= '0;
    end else if (wr) begin
      if (sel_ctrl) begin
        ctrl_q.vector   <= reg_wdata[7:0];
        ctrl_q.mask     <= reg_wdata[BIT_MASK];
        ctrl_q.periodic <= reg_wdata[BIT_MODE];
      end
      if (sel_div)   div_q   <= {reg_wdata[3], reg_wdata[1:0]};
      if (sel_start) start_q <= reg_wdata[CNT_W-1:0];
    end
  end

  assign start_stb = wr & sel_start;
  assign ctrl      = ctrl_q;
  assign div_code  = div_q;
  assign start_cnt = start_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_we) begin
      if (sel_ctrl) begin
        reg_rdata[7:0]      = ctrl_q.vector;
        reg_rdata[BIT_BUSY] = busy;
        reg_rdata[BIT_MASK] = ctrl_q.mask;
        reg_rdata[BIT_MODE] = ctrl_q.periodic;
      end
      if (sel_start) reg_rdata[CNT_W-1:0] = start_q;
      if (sel_live)  reg_rdata[CNT_W-1:0] = live_cnt;
      if (sel_div) begin
        reg_rdata[3]   = div_q[2];
        reg_rdata[1:0] = div_q[1:0];
      end
    end
  end
endmodule

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler
  import ctmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] div_code,
  output logic       tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] cmp;

  assign cmp  = div_mask(div_code);
  assign tick = ((phase_q & cmp) == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] live_cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  assign expire   = !load && tick && (cnt_q == ONE);
  assign live_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (tick && cnt_q != '0) begin
      if (cnt_q == ONE && periodic)  cnt_q <= reload_val;
      else                           cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/ctmr_delivery.sv
module ctmr_delivery (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       mask,
  input  logic [7:0] vector,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] vec_out
);
  logic pend_q;
  logic [7:0] vec_q;
  logic raise, take;

  assign raise = expire & ~mask;
  assign take  = pend_q & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= 8'h00;
    end else if (raise && (!pend_q || take)) begin
      pend_q <= 1'b1;
      vec_q  <= vector;
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

  assign valid   = pend_q;
  assign vec_out = vec_q;
endmodule

// File: rtl/core_timer.sv
module core_timer
  import ctmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [7:0]        irq_vector,
  input  logic              irq_ready
);
  ctrl_t            ctrl;
  logic [2:0]       div_code;
  logic             start_stb;
  logic [CNT_W-1:0] start_cnt;
  logic [CNT_W-1:0] live_cnt;
  logic             tick;
  logic             expire;
  logic             lvt_mask;

  assign lvt_mask = ctrl.mask;

  ctmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .live_cnt(live_cnt), .busy(irq_valid), .ctrl(ctrl), .div_code(div_code),
    .start_stb(start_stb), .start_cnt(start_cnt)
  );

  ctmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start_stb), .div_code(div_code),
    .tick(tick)
  );

  ctmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_stb),
    .load_val(reg_wdata[CNT_W-1:0]), .reload_val(start_cnt),
    .periodic(ctrl.periodic), .tick(tick), .live_cnt(live_cnt),
    .expire(expire)
  );

  ctmr_delivery u_dlv (
    .clk(clk), .rst_n(rst_n), .expire(expire), .mask(ctrl.mask),
    .vector(ctrl.vector), .ready(irq_ready), .valid(irq_valid),
    .vec_out(irq_vector)
  );
endmodule

// File: rtl/core_timer_checker.sv
module core_timer_checker
  import ctmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [CNT_W-1:0]  load_val,
  input logic              irq_valid,
  input logic [7:0]        irq_vector,
  input logic              irq_ready,
  input logic [CNT_W-1:0]  live_cnt,
  input logic              load_stb,
  input logic              lvt_mask
);
  localparam int SLOT_W = ADDR_W - 4;
  logic rd_ctrl, rd_div;
  logic unused_low;
  assign unused_low = ^reg_addr[3:0];
  assign rd_ctrl = reg_en && !reg_we && (reg_addr[ADDR_W-1:4] == SLOT_W'(OFF_CTRL >> 4));
  assign rd_div  = reg_en && !reg_we && (reg_addr[ADDR_W-1:4] == SLOT_W'(OFF_DIV >> 4));

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid); // R10
  AST_VECTOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> $stable(irq_vector)); // R10
  AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> reg_rdata[BIT_BUSY] == irq_valid); // R10
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (reg_rdata[DATA_W-1:18] == '0 && reg_rdata[15:13] == '0 && reg_rdata[11:8] == '0)); // R2
  AST_DIV_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_div |-> (reg_rdata[DATA_W-1:4] == '0 && reg_rdata[2] == 1'b0)); // R3
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> live_cnt == $past(load_val)); // R4
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt == '0 && !load_stb |=> live_cnt == '0); // R12
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(!lvt_mask)); // R9
endmodule

bind core_timer core_timer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .load_val(reg_wdata[CNT_W-1:0]),
  .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ready(irq_ready),
  .live_cnt(live_cnt), .load_stb(start_stb), .lvt_mask(lvt_mask)
);

// File: tb/core_timer_test.sv
module core_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h320, A_START = 12'h380,
                          A_LIVE = 12'h390, A_DIV = 12'h3E0;
  // {divider register value, start count, expected edges to interrupt}
  localparam int TBL [8][3] = '{
    '{32'h0, 5, 10}, '{32'h1, 3, 12}, '{32'h2, 3, 24}, '{32'h3, 2, 32},
    '{32'h8, 2, 64}, '{32'h9, 2, 128}, '{32'hA, 2, 256}, '{32'hB, 7, 7}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_valid, irq_ready = 1'b0;
  logic [7:0] irq_vector;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ready(irq_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic wait_irq(output int edges);
    edges = 0;
    while (!irq_valid && edges < 2000) begin
      @(posedge clk); edges++; @(negedge clk);
    end
  endtask

  task automatic ack();
    irq_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d);  check("R1 ctrl", d, 32'h0001_0000);
    rd(A_START, d); check("R1 start", d, 0);
    rd(A_LIVE, d);  check("R1 live", d, 0);
    rd(A_DIV, d);   check("R1 div", d, 0);
    check("R1 irq_valid", {31'b0, irq_valid}, 0);

    // R2 / R3 reserved bits, R13 live count not writable
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); check("R2 ctrl all ones", d, 32'h0003_00FF);
    wr(A_DIV, 32'hFFFF_FFFF);  rd(A_DIV, d);  check("R3 div all ones", d, 32'h0000_000B);
    wr(A_LIVE, 32'h1234);      rd(A_LIVE, d); check("R13 live write ignored", d, 0);

    // R5 R6 R10 R4 R7: divider table, one-shot
    for (int i = 0; i < 8; i++) begin
      wr(A_DIV, TBL[i][0]);
      wr(A_CTRL, 32'h40 + i);
      wr(A_START, TBL[i][1]);
      rd(A_LIVE, d); check("R4 live loaded", d, TBL[i][1]);
      wait_irq(e);
      check("R5 R6 edges to interrupt", e, TBL[i][2]);
      check("R10 vector", {24'b0, irq_vector}, 32'h40 + i);
      rd(A_CTRL, d); check("R10 busy set", {31'b0, d[12]}, 1);
      idle(3);
      check("R10 held without ready", {31'b0, irq_valid}, 1);
      ack();
      check("R10 cleared by ready", {31'b0, irq_valid}, 0);
      rd(A_LIVE, d); check("R7 live stays zero", d, 0);
    end
    idle(300);
    check("R7 no second one-shot interrupt", {31'b0, irq_valid}, 0);

    // R8 periodic, divide by 1, N = 5
    wr(A_DIV, 32'hB);
    wr(A_CTRL, 32'h0002_0077);
    wr(A_START, 5);
    wait_irq(e); check("R8 first period", e, 5);
    ack();
    wait_irq(e); check("R8 second period after ready", e, 4);
    ack();
    wait_irq(e); check("R8 third period after ready", e, 4);
    ack();

    // R11 expiries while pending are dropped (N = 3)
    wr(A_START, 3);
    wait_irq(e); check("R11 first expiry", e, 3);
    idle(10);
    ack();
    check("R11 nothing queued after ready", {31'b0, irq_valid}, 0);
    wait_irq(e); check("R11 next expiry only", e, 1);
    ack();

    // R12 start count zero stops
    wr(A_START, 0);
    rd(A_LIVE, d); check("R12 live zero", d, 0);
    idle(40);
    check("R12 no interrupt after stop", {31'b0, irq_valid}, 0);

    // R9 mask silences periodic expiries
    wr(A_CTRL, 32'h0003_0055);
    wr(A_START, 4);
    idle(30);
    check("R9 masked no interrupt", {31'b0, irq_valid}, 0);
    rd(A_CTRL, d); check("R9 busy clear while masked", {31'b0, d[12]}, 0);
    wr(A_START, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule